// File: doc/BRIEF.md
# Interrupt mask and priority register bank with per-field enable pulses

This block holds the mask and priority registers of an interrupt controller. Software reaches them through one 32-bit write port. Each register may answer at a set address, at a clear address, or at both. The addresses that are defined for a register decide how a write is merged into the stored value.

After every write, each field of the touched register is compared with its old contents. A field that changes sends a one-cycle enable or disable pulse to the interrupt source it is wired to. Which source each field drives is fixed by a parameter, and one register's fields may drive any source. Mask registers have one-bit fields. Priority registers have wider fields, and each field counts as enabled when it holds any non-zero value.

The source-side logic consumes the pulses. That logic keeps enable counts and pending state, and it is not part of this block. Reads use the same address input and return the stored value of the register that matches.

Top module: `intc_mask_bank`

## Requirements
- R1: Only the low 29 bits of an incoming address take part in matching. An address that differs only in bits 31..29, such as 0xE000_0110 against 0x110, reaches the same register.
- R2: On a register with both a set and a clear address, a write to the set address stores the old value OR the write data.
- R3: On a register with both addresses, a write to the clear address stores the old value AND the inverted write data.
- R4: A register with a single address stores the write data unchanged. This holds whether that address is a set address or a clear address.
- R5: With field width W, a register has 32/W fields. Field k occupies bits (32/W-1-k)*W upward, so field 0 is the top field. Default layout:
  - register 0: set 0x100, clear 0x104, W=1, field k drives source k for k<16.
  - register 1: clear only 0x108, W=1, field k drives source 16+k for k<8.
  - register 2: set only 0x110, W=4, field k drives source 24+k.
  - register 3: set 0x114, clear 0x118, W=8, field k drives source 32+k.
  - All other fields drive no source.
- R6: A field whose new value equals its old value sends no pulse, including on a repeated identical write.
- R7: A changed field raises its source's bit on `src_en_pulse` if its new value is non-zero, and on `src_dis_pulse` if its new value is zero.
- R8: Pulses appear in the cycle after the write edge and last exactly one cycle. All pulses from one write appear in the same cycle, and no pulse appears without a write in the preceding cycle.
- R9: A write to an address that matches no register changes nothing and sends no pulse. A read of such an address returns zero. Address 0 never matches.
- R10: During and after reset, every register reads zero and both pulse outputs are zero.
- R11: `rd_data` combinationally returns the stored value of the register at either of its addresses. It changes only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address and data |
| addr | input | 32 | Register address, used for both reads and writes |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Stored value of the matched register, or zero |
| src_en_pulse | output | 36 | One-cycle enable pulses, one bit per source |
| src_dis_pulse | output | 36 | One-cycle disable pulses, one bit per source |

## Verification
A stored value that is corrupt shows up at once on `rd_data` when its address is read. The first write that touches a corrupt field also shows it, one cycle later, as a missing or extra pulse on the source that field drives. A wrong merge mode or a wrong field position gives a pulse on the wrong source, or of the wrong polarity, in the cycle right after the write. The bench compares every output against a behavioural model on every clock, so each such fault shows within one cycle of the first stimulus that exposes it.

// File: rtl/intc_bank_pkg.sv
package intc_bank_pkg;

   localparam int DEF_REGS  = 4;
   localparam int DEF_REG_W = 32;
   localparam int DEF_IDW   = 8;

   typedef enum logic [1:0] {
      WR_KEEP,
      WR_OR,
      WR_ANDN,
      WR_LOAD
   } wr_kind_e;

   // Two defined addresses clash when they coincide after masking.
   function automatic bit addr_clash(input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] keep);
      return (a != 32'd0) && (b != 32'd0) && ((a & keep) == (b & keep));
   endfunction

   // Default field-to-source wiring; unused fields carry the all-ones id.
   function automatic logic [DEF_REGS*DEF_REG_W*DEF_IDW-1:0] default_src_map();
      logic [DEF_REGS*DEF_REG_W*DEF_IDW-1:0] m;
      m = '1;
      for (int k = 0; k < 16; k++) m[(0*DEF_REG_W + k)*DEF_IDW +: DEF_IDW] = 8'(k);
      for (int k = 0; k < 8;  k++) m[(1*DEF_REG_W + k)*DEF_IDW +: DEF_IDW] = 8'(16 + k);
      for (int k = 0; k < 8;  k++) m[(2*DEF_REG_W + k)*DEF_IDW +: DEF_IDW] = 8'(24 + k);
      for (int k = 0; k < 4;  k++) m[(3*DEF_REG_W + k)*DEF_IDW +: DEF_IDW] = 8'(32 + k);
      return m;
   endfunction

endpackage

// File: rtl/intc_bank_decode.sv
module intc_bank_decode #(
   parameter int                        REG_COUNT = 4,
   parameter logic [31:0]               KEEP_MASK = 32'h1FFF_FFFF,
   parameter logic [REG_COUNT*32-1:0]   SET_ADDRS = '0,
   parameter logic [REG_COUNT*32-1:0]   CLR_ADDRS = '0
) (
   input  logic [31:0]          addr,
   output logic [REG_COUNT-1:0] hit_set,
   output logic [REG_COUNT-1:0] hit_clr
);

   logic [31:0] addr_low;
   assign addr_low = addr & KEEP_MASK;

   for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
      localparam logic [31:0] SA = SET_ADDRS[r*32 +: 32];
      localparam logic [31:0] CA = CLR_ADDRS[r*32 +: 32];
      if (SA != 32'd0) begin : g_set
         assign hit_set[r] = (addr_low == (SA & KEEP_MASK));
      end else begin : g_noset
         assign hit_set[r] = 1'b0;
      end
      if (CA != 32'd0) begin : g_clr
         assign hit_clr[r] = (addr_low == (CA & KEEP_MASK));
      end else begin : g_noclr
         assign hit_clr[r] = 1'b0;
      end
   end

endmodule

// File: rtl/intc_bank_reg.sv
module intc_bank_reg
   import intc_bank_pkg::*;
#(
   parameter int                        REG_W     = 32,
   parameter int                        FIELD_W   = 1,
   parameter bit                        HAS_SET   = 1'b1,
   parameter bit                        HAS_CLR   = 1'b1,
   parameter int                        SRC_COUNT = 36,
   parameter int                        IDW       = 8,
   parameter logic [REG_W*IDW-1:0]      MAP       = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 hit_set,
   input  logic                 hit_clr,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     value,
   output logic [SRC_COUNT-1:0] en_vec,
   output logic [SRC_COUNT-1:0] dis_vec
);

   localparam int NF = REG_W / FIELD_W;
   localparam int SW = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1;

   wr_kind_e         kind;
   logic [REG_W-1:0] next_val;
   logic [NF-1:0]    fld_chg;
   logic [NF-1:0]    fld_nz;

   if (HAS_SET && HAS_CLR) begin : g_dual
      always_comb begin
         kind = WR_KEEP;
         if (wr_en && hit_set)      kind = WR_OR;
         else if (wr_en && hit_clr) kind = WR_ANDN;
      end
   end else if (HAS_SET || HAS_CLR) begin : g_single
      always_comb begin
         kind = WR_KEEP;
         if (wr_en && (hit_set || hit_clr)) kind = WR_LOAD;
      end
   end else begin : g_absent
      assign kind = WR_KEEP;
   end

   always_comb begin
      unique case (kind)
         WR_OR:   next_val = value | wdata;
         WR_ANDN: next_val = value & ~wdata;
         WR_LOAD: next_val = wdata;
         default: next_val = value;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= next_val;
   end

   // Field 0 sits at the top of the register.
   for (genvar k = 0; k < NF; k++) begin : g_fld
      localparam int LSB = (NF - 1 - k) * FIELD_W;
      assign fld_chg[k] = (value[LSB +: FIELD_W] != next_val[LSB +: FIELD_W]);
      assign fld_nz[k]  = |next_val[LSB +: FIELD_W];
   end

   always_comb begin
      logic [IDW-1:0] sid;
      en_vec  = '0;
      dis_vec = '0;
      for (int k = 0; k < NF; k++) begin
         sid = MAP[k*IDW +: IDW];
         if (32'(sid) < SRC_COUNT) begin
            en_vec[sid[SW-1:0]]  = en_vec[sid[SW-1:0]]  | (fld_chg[k] &  fld_nz[k]);
            dis_vec[sid[SW-1:0]] = dis_vec[sid[SW-1:0]] | (fld_chg[k] & ~fld_nz[k]);
         end
      end
   end

endmodule

// File: rtl/intc_bank_rdmux.sv
module intc_bank_rdmux #(
   parameter int REG_COUNT = 4,
   parameter int REG_W     = 32
) (
   input  logic [REG_COUNT-1:0]       hit,
   input  logic [REG_COUNT*REG_W-1:0] values,
   output logic [REG_W-1:0]           rd_data
);

   // Lowest register index wins; unique addresses make this moot.
   always_comb begin
      rd_data = '0;
      for (int r = REG_COUNT - 1; r >= 0; r--) begin
         if (hit[r]) rd_data = values[r*REG_W +: REG_W];
      end
   end

endmodule

// File: rtl/intc_pulse_merge.sv
module intc_pulse_merge #(
   parameter int REG_COUNT = 4,
   parameter int SRC_COUNT = 36
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [REG_COUNT*SRC_COUNT-1:0] en_all,
   input  logic [REG_COUNT*SRC_COUNT-1:0] dis_all,
   output logic [SRC_COUNT-1:0]           en_q,
   output logic [SRC_COUNT-1:0]           dis_q
);

   logic [SRC_COUNT-1:0] en_or;
   logic [SRC_COUNT-1:0] dis_or;

   always_comb begin
      en_or  = '0;
      dis_or = '0;
      for (int r = 0; r < REG_COUNT; r++) begin
         en_or  = en_or  | en_all[r*SRC_COUNT +: SRC_COUNT];
         dis_or = dis_or | dis_all[r*SRC_COUNT +: SRC_COUNT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         dis_q <= '0;
      end else begin
         en_q  <= en_or;
         dis_q <= dis_or;
      end
   end

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
   import intc_bank_pkg::*;
#(
   parameter int                               REG_COUNT      = DEF_REGS,
   parameter int                               REG_W          = DEF_REG_W,
   parameter int                               SRC_COUNT      = 36,
   parameter int                               IDW            = DEF_IDW,
   parameter int                               ADDR_KEEP_BITS = 29,
   parameter logic [REG_COUNT*32-1:0]          SET_ADDRS      = {32'h114, 32'h110, 32'h000, 32'h100},
   parameter logic [REG_COUNT*32-1:0]          CLR_ADDRS      = {32'h118, 32'h000, 32'h108, 32'h104},
   parameter logic [REG_COUNT*8-1:0]           FIELD_WS       = {8'd8, 8'd4, 8'd1, 8'd1},
   parameter logic [REG_COUNT*REG_W*IDW-1:0]   SRC_MAP        = default_src_map()
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [31:0]          addr,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rd_data,
   output logic [SRC_COUNT-1:0] src_en_pulse,
   output logic [SRC_COUNT-1:0] src_dis_pulse
);

   localparam logic [31:0] KEEP_MASK = 32'((64'd1 << ADDR_KEEP_BITS) - 64'd1);

   // Elaboration checks on the configuration.
   if (REG_W > 32 || REG_W < 1) begin : g_bad_w
      $error("register width must be 1..32");
   end
   if (SRC_COUNT < 1 || SRC_COUNT > (1 << IDW) - 1) begin : g_bad_src
      $error("source count must fit below the all-ones id");
   end
   if (ADDR_KEEP_BITS < 1 || ADDR_KEEP_BITS > 32) begin : g_bad_keep
      $error("address keep width must be 1..32");
   end
   for (genvar r = 0; r < REG_COUNT; r++) begin : g_chk
      localparam int FW = int'(FIELD_WS[r*8 +: 8]);
      if (FW == 0 || (REG_W % FW) != 0) begin : g_bad_fw
         $error("field width must divide the register width");
      end
      if (addr_clash(SET_ADDRS[r*32 +: 32], CLR_ADDRS[r*32 +: 32], KEEP_MASK)) begin : g_self
         $error("set and clear address coincide");
      end
      for (genvar q = r + 1; q < REG_COUNT; q++) begin : g_pair
         if (addr_clash(SET_ADDRS[r*32 +: 32], SET_ADDRS[q*32 +: 32], KEEP_MASK) ||
             addr_clash(SET_ADDRS[r*32 +: 32], CLR_ADDRS[q*32 +: 32], KEEP_MASK) ||
             addr_clash(CLR_ADDRS[r*32 +: 32], SET_ADDRS[q*32 +: 32], KEEP_MASK) ||
             addr_clash(CLR_ADDRS[r*32 +: 32], CLR_ADDRS[q*32 +: 32], KEEP_MASK)) begin : g_dup
            $error("two registers share an address");
         end
      end
   end

   logic [REG_COUNT-1:0]           hit_set;
   logic [REG_COUNT-1:0]           hit_clr;
   logic [REG_COUNT*REG_W-1:0]     reg_vals;
   logic [REG_COUNT*SRC_COUNT-1:0] en_all;
   logic [REG_COUNT*SRC_COUNT-1:0] dis_all;

   intc_bank_decode #(
      .REG_COUNT (REG_COUNT),
      .KEEP_MASK (KEEP_MASK),
      .SET_ADDRS (SET_ADDRS),
      .CLR_ADDRS (CLR_ADDRS)
   ) u_decode (
      .addr    (addr),
      .hit_set (hit_set),
      .hit_clr (hit_clr)
   );

   for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
      intc_bank_reg #(
         .REG_W     (REG_W),
         .FIELD_W   (int'(FIELD_WS[r*8 +: 8])),
         .HAS_SET   (SET_ADDRS[r*32 +: 32] != 32'd0),
         .HAS_CLR   (CLR_ADDRS[r*32 +: 32] != 32'd0),
         .SRC_COUNT (SRC_COUNT),
         .IDW       (IDW),
         .MAP       (SRC_MAP[r*REG_W*IDW +: REG_W*IDW])
      ) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .hit_set (hit_set[r]),
         .hit_clr (hit_clr[r]),
         .wdata   (wdata),
         .value   (reg_vals[r*REG_W +: REG_W]),
         .en_vec  (en_all[r*SRC_COUNT +: SRC_COUNT]),
         .dis_vec (dis_all[r*SRC_COUNT +: SRC_COUNT])
      );
   end

   intc_bank_rdmux #(
      .REG_COUNT (REG_COUNT),
      .REG_W     (REG_W)
   ) u_rdmux (
      .hit     (hit_set | hit_clr),
      .values  (reg_vals),
      .rd_data (rd_data)
   );

   intc_pulse_merge #(
      .REG_COUNT (REG_COUNT),
      .SRC_COUNT (SRC_COUNT)
   ) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_all  (en_all),
      .dis_all (dis_all),
      .en_q    (src_en_pulse),
      .dis_q   (src_dis_pulse)
   );

endmodule

// File: rtl/intc_bank_checker.sv
module intc_bank_checker #(
   parameter int REG_W     = 32,
   parameter int SRC_COUNT = 36
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [31:0]          addr,
   input logic [REG_W-1:0]     wdata,
   input logic [REG_W-1:0]     rd_data,
   input logic [SRC_COUNT-1:0] src_en_pulse,
   input logic [SRC_COUNT-1:0] src_dis_pulse
);

   AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_en_pulse != '0) || (src_dis_pulse != '0)) |-> $past(wr_en)); // R8

   AST_READ_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $stable(addr)) |-> $stable(rd_data)); // R11

   AST_REPEAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_en, 2) && ($past(addr) == $past(addr, 2)) &&
       ($past(wdata) == $past(wdata, 2)))
      |-> ((src_en_pulse == '0) && (src_dis_pulse == '0))); // R6

   AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en)) |-> ((src_en_pulse == '0) && (src_dis_pulse == '0))); // R8

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert ((src_en_pulse == '0) && (src_dis_pulse == '0)); // R10
      end
   end

endmodule

bind intc_mask_bank intc_bank_checker #(
   .REG_W     (REG_W),
   .SRC_COUNT (SRC_COUNT)
) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .addr          (addr),
   .wdata         (wdata),
   .rd_data       (rd_data),
   .src_en_pulse  (src_en_pulse),
   .src_dis_pulse (src_dis_pulse)
);

// File: tb/intc_mask_bank_test.sv
module intc_mask_bank_test;

   localparam int NSRC = 36;

   logic              clk   = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [31:0]       addr  = 32'd0;
   logic [31:0]       wdata = 32'd0;
   logic [31:0]       rd_data;
   logic [NSRC-1:0]   en_p;
   logic [NSRC-1:0]   dis_p;

   always #4 clk = ~clk;

   intc_mask_bank uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .addr          (addr),
      .wdata         (wdata),
      .rd_data       (rd_data),
      .src_en_pulse  (en_p),
      .src_dis_pulse (dis_p)
   );

   int    checks = 0;
   int    errors = 0;
   string tag    = "R10";

   bit [31:0]     m_val [4];
   bit [NSRC-1:0] m_en;
   bit [NSRC-1:0] m_dis;

   // Default layout as stated in the requirements (R5).
   function automatic bit [31:0] set_of(int r);
      case (r) 0: return 32'h100; 2: return 32'h110; 3: return 32'h114; default: return 32'h0; endcase
   endfunction
   function automatic bit [31:0] clr_of(int r);
      case (r) 0: return 32'h104; 1: return 32'h108; 3: return 32'h118; default: return 32'h0; endcase
   endfunction
   function automatic int width_of(int r);
      case (r) 2: return 4; 3: return 8; default: return 1; endcase
   endfunction
   function automatic int src_of(int r, int k);
      case (r)
         0: return (k < 16) ? k : -1;
         1: return (k < 8) ? 16 + k : -1;
         2: return 24 + k;
         default: return 32 + k;
      endcase
   endfunction
   function automatic int find_reg(bit [31:0] a, output bit is_clr);
      bit [31:0] low = a & 32'h1FFF_FFFF;  // R1
      is_clr = 1'b0;
      for (int r = 0; r < 4; r++) begin
         if (set_of(r) != 0 && low == set_of(r)) return r;
         if (clr_of(r) != 0 && low == clr_of(r)) begin
            is_clr = 1'b1;
            return r;
         end
      end
      return -1;
   endfunction

   // Reference model, updated on each rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < 4; r++) m_val[r] = 0;
         m_en  = 0;
         m_dis = 0;
      end else begin
         m_en  = 0;
         m_dis = 0;
         if (wr_en) begin
            bit isc;
            int r;
            r = find_reg(addr, isc);
            if (r >= 0) begin
               bit [31:0] nv;
               int fw, nf;
               if (set_of(r) != 0 && clr_of(r) != 0)
                  nv = isc ? (m_val[r] & ~wdata) : (m_val[r] | wdata);  // R2 R3
               else
                  nv = wdata;                                          // R4
               fw = width_of(r);
               nf = 32 / fw;
               for (int k = 0; k < nf; k++) begin
                  int sh, s;
                  bit [31:0] om, nm;
                  sh = (nf - 1 - k) * fw;
                  om = (m_val[r] >> sh) & ((32'd1 << fw) - 1);
                  nm = (nv >> sh) & ((32'd1 << fw) - 1);
                  s  = src_of(r, k);
                  if (s >= 0 && om != nm) begin                        // R6 R7
                     if (nm != 0) m_en[s]  = 1'b1;
                     else         m_dis[s] = 1'b1;
                  end
               end
               m_val[r] = nv;
            end
         end
      end
   end

   task automatic check(string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Compare all outputs shortly after every rising edge.
   initial begin
      forever begin
         bit isc;
         int r;
         bit [31:0] exp_rd;
         @(posedge clk);
         #2;
         r = find_reg(addr, isc);
         exp_rd = (r >= 0) ? m_val[r] : 32'h0;                        // R9 R11
         check("rd_data", 64'(rd_data), 64'(exp_rd));
         check("src_en_pulse", 64'(en_p), 64'(m_en));
         check("src_dis_pulse", 64'(dis_p), 64'(m_dis));
      end
   end

   task automatic put(bit [31:0] a, bit [31:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
   endtask
   task automatic look(bit [31:0] a);
      @(negedge clk);
      wr_en = 1'b0;
      addr  = a;
   endtask
   task automatic wr1(bit [31:0] a, bit [31:0] d);
      put(a, d);
      look(a);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL R8 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit [31:0] alist [9];
      alist = '{32'h100, 32'h104, 32'h108, 32'h110, 32'h114, 32'h118,
                32'h200, 32'hE000_0104, 32'hA000_0114};

      // R10: reset state
      tag = "R10";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look(32'h100); look(32'h108); look(32'h110); look(32'h114);

      // R2: set-OR on the dual mask register, including unwired bits
      tag = "R2";
      wr1(32'h100, 32'h8001_0000);
      wr1(32'h100, 32'h0000_0003);
      wr1(32'h100, 32'h4000_0000);

      // R6: identical write repeated back to back
      tag = "R6";
      put(32'h100, 32'hC001_0000);
      put(32'h100, 32'hC001_0000);
      look(32'h100);

      // R3: clear-ANDN on the dual mask register
      tag = "R3";
      wr1(32'h104, 32'h8000_0000);
      wr1(32'h104, 32'hFFFF_FFFF);

      // R4: clear-only and set-only registers store directly
      tag = "R4";
      wr1(32'h108, 32'hA500_0000);
      wr1(32'h108, 32'h5A00_0000);
      wr1(32'h110, 32'h1234_5678);
      wr1(32'h110, 32'h1034_0078);

      // R5: field placement on the wide priority register
      tag = "R5";
      wr1(32'h114, 32'h0100_0000);
      wr1(32'h114, 32'h0000_0080);
      wr1(32'h118, 32'h0100_0000);
      wr1(32'h118, 32'h0000_0001);

      // R7: enable and disable in one write
      tag = "R7";
      wr1(32'h110, 32'h0F00_0000);

      // R1: aliased upper address bits
      tag = "R1";
      wr1(32'hE000_0110, 32'h0000_0000);
      wr1(32'h2000_0114, 32'hFF00_0000);

      // R9: unmapped addresses
      tag = "R9";
      wr1(32'h200, 32'hFFFF_FFFF);
      wr1(32'h10C, 32'hFFFF_FFFF);
      wr1(32'h0, 32'hFFFF_FFFF);
      look(32'h114);

      // R11: read through both addresses of dual registers
      tag = "R11";
      look(32'h104); look(32'h100); look(32'h118); look(32'hE000_0118);

      // R8: back-to-back writes to different registers
      tag = "R8";
      put(32'h100, 32'h0000_8000);
      put(32'h108, 32'h0100_0000);
      put(32'h110, 32'hFFFF_FFFF);
      put(32'h118, 32'hFFFF_FFFF);
      look(32'h110);

      // R7: mixed traffic
      tag = "R7";
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         addr  = alist[$urandom_range(0, 8)];
         wdata = $urandom();
         if ($urandom_range(0, 3) == 0) wdata = wdata & 32'hF0F0_0000;
         wr_en = ($urandom_range(0, 3) != 0);
      end
      look(32'h100);
      look(32'h100);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule